// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block drives a parallel RGB LCD panel. It runs a horizontal and a vertical position counter and decodes from them the horizontal sync, vertical sync and data-enable signals. It takes pixels from an upstream stream, formats them for the panel bus and shows where each line and frame begins. All geometry comes from configuration words that software sets up before the block leaves reset: two sync widths, one packed word of totals and two packed active windows. The windows are absolute counter positions measured from the leading edge of sync.

A configuration word sets the panel mode, the parallel bus width, the active level of each sync and enable output, and the pixel clock sampling edge. In the two parallel modes the block presents one pixel per enabled cycle on 16 or 18 data pins. In the 8-bit serial mode it sends each pixel as three colour beats on the low 8 pins, and the line timing is still counted in pixels. The pixel clock is generated outside the block. The `tick_en` input qualifies each beat, and the block reports the chosen sampling edge on its own pin.

Top module: `lcd_timing_gen`

## Requirements
- R1: The horizontal counter starts at 0 and wraps to 0 after the value h_total-1. The vertical counter advances only when the horizontal counter wraps, and it wraps to 0 after v_total-1.
- R2: Horizontal sync is active while the horizontal count is below `hs_width`, and vertical sync is active while the vertical count is below `vs_width`. Both widths are 10-bit.
- R3: Data-enable is active only when the horizontal count is in [h_start, h_end) and the vertical count is in [v_start, v_end).
- R4: `timing_total` carries h_total in bits 31:16 and v_total in bits 15:0. `h_window` and `v_window` each carry the start in bits 31:16 and the end in bits 15:0.
- R5: Each configuration bit inverts one output to active-low: bit 11 inverts hsync, bit 8 inverts vsync and bit 9 inverts data-enable. Bit 10 selects falling-edge sampling and appears on `lcd_pclk_fall`.
- R6: Configuration bits 3:0 select the panel mode: 4'h1 is 8-bit serial and every other value is parallel. A parallel pixel uses 16-bit RGB565 with red in bits 15:11, green in bits 10:5 and blue in bits 4:0, and bits 17:16 are zero. The colour is taken from the top bits of each 8-bit component of `pix_rgb` (red 23:16, green 15:8, blue 7:0).
- R7: In parallel mode, configuration bit 7 selects the 18-bit bus: red[7:2] in bits 17:12, green[7:2] in bits 11:6 and blue[7:2] in bits 5:0.
- R8: In serial mode each pixel takes three consecutive enabled cycles that carry red, then green, then blue on bits 7:0, with bits 17:8 zero. The horizontal count advances once per three beats.
- R9: Data is zero whenever data-enable is inactive. `pix_take` is high only on an enabled cycle inside the active window and, in serial mode, only on the first beat of a pixel.
- R10: When `tick_en` is low, every panel and status output holds its value and the position does not advance.
- R11: While `rst` is high, the counters clear, sync and enable sit at their inactive levels, and data and status are zero.
- R12: `line_start` marks the first beat at horizontal count 0. `frame_start` marks that beat when the vertical count is also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Beat qualifier; one panel beat per high cycle |
| cfg_word | input | 12 | Mode, bus width, polarities, sampling edge |
| hs_width | input | 10 | Horizontal sync width in pixels |
| vs_width | input | 10 | Vertical sync width in lines |
| timing_total | input | 32 | Packed horizontal and vertical totals |
| h_window | input | 32 | Packed horizontal active start and end |
| v_window | input | 32 | Packed vertical active start and end |
| pix_rgb | input | 24 | Incoming pixel, 8 bits per colour |
| pix_take | output | 1 | Pixel on pix_rgb is consumed at this edge |
| lcd_hsync | output | 1 | Horizontal sync pin |
| lcd_vsync | output | 1 | Vertical sync pin |
| lcd_de | output | 1 | Data-enable pin |
| lcd_data | output | 18 | Panel data pins |
| lcd_pclk_fall | output | 1 | Selected pixel clock sampling edge |
| line_start | output | 1 | First beat of a line |
| frame_start | output | 1 | First beat of a frame |

## Verification
The checker watches several rules on every cycle. It checks that outputs hold across a stalled cycle, that data is zero outside data-enable, and that pixel consumption only happens on enabled cycles. It also checks that the upper data pins stay clear in serial mode, that a frame marker always coincides with a line marker and an active horizontal sync, and that the sampling-edge pin follows its configuration bit. The exact positions of the sync and window edges, the wrap points of both counters, the bit mapping of each bus mode and the red-green-blue order of the serial beats cannot be seen from any single cycle. The bench's scenarios show those by comparing every beat of whole frames against positions it computes itself, in each mode and polarity setting and with stalls.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int CFG_W         = 12;
  localparam int CFG_MODE_LSB  = 0;
  localparam int CFG_MODE_W    = 4;
  localparam int CFG_BUS18     = 7;
  localparam int CFG_VS_LOW    = 8;
  localparam int CFG_DE_LOW    = 9;
  localparam int CFG_PCLK_FALL = 10;
  localparam int CFG_HS_LOW    = 11;

  typedef enum logic [CFG_MODE_W-1:0] {
    MODE_PARALLEL = 4'h0,
    MODE_SERIAL8  = 4'h1
  } panel_mode_e;

  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
    logic line_first;
    logic frame_first;
  } tg_flags_t;
endpackage

// File: rtl/lcd_tg_counter.sv
module lcd_tg_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             serial,
  input  logic [CNT_W-1:0] h_total,
  input  logic [CNT_W-1:0] v_total,
  output logic [CNT_W-1:0] h_cnt,
  output logic [CNT_W-1:0] v_cnt,
  output logic [1:0]       beat
);
  localparam logic [1:0] LAST_BEAT = 2'd2;

  logic pixel_step;
  logic h_last;
  logic v_last;

  assign pixel_step = !serial || (beat == LAST_BEAT);
  assign h_last     = (h_cnt == h_total - 1'b1);
  assign v_last     = (v_cnt == v_total - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      h_cnt <= '0;
      v_cnt <= '0;
      beat  <= '0;
    end else if (tick_en) begin
      if (!pixel_step) begin
        beat <= beat + 1'b1;
      end else begin
        beat <= '0;
        if (h_last) begin
          h_cnt <= '0;
          v_cnt <= v_last ? '0 : v_cnt + 1'b1;
        end else begin
          h_cnt <= h_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lcd_tg_window.sv
module lcd_tg_window
  import lcd_tg_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SYNC_W = 10
) (
  input  logic [CNT_W-1:0]  h_cnt,
  input  logic [CNT_W-1:0]  v_cnt,
  input  logic [1:0]        beat,
  input  logic [SYNC_W-1:0] hs_width,
  input  logic [SYNC_W-1:0] vs_width,
  input  logic [CNT_W-1:0]  h_start,
  input  logic [CNT_W-1:0]  h_end,
  input  logic [CNT_W-1:0]  v_start,
  input  logic [CNT_W-1:0]  v_end,
  output tg_flags_t         flags
);
  localparam int PAD_W = CNT_W - SYNC_W;

  logic [CNT_W-1:0] hs_w_ext;
  logic [CNT_W-1:0] vs_w_ext;
  logic             h_in;
  logic             v_in;

  assign hs_w_ext = {{PAD_W{1'b0}}, hs_width};
  assign vs_w_ext = {{PAD_W{1'b0}}, vs_width};
  assign h_in     = (h_cnt >= h_start) && (h_cnt < h_end);
  assign v_in     = (v_cnt >= v_start) && (v_cnt < v_end);

  always_comb begin
    flags.hs          = h_cnt < hs_w_ext;
    flags.vs          = v_cnt < vs_w_ext;
    flags.de          = h_in && v_in;
    flags.line_first  = (h_cnt == '0) && (beat == 2'd0);
    flags.frame_first = flags.line_first && (v_cnt == '0);
  end
endmodule

// File: rtl/lcd_tg_pixfmt.sv
module lcd_tg_pixfmt #(
  parameter int COMP_W = 8,
  parameter int DATA_W = 18
) (
  input  logic              serial,
  input  logic              bus18,
  input  logic [1:0]        beat,
  input  logic [3*COMP_W-1:0] live_rgb,
  input  logic [3*COMP_W-1:0] held_rgb,
  output logic [DATA_W-1:0] data
);
  localparam int C6 = 6;
  localparam int C5 = 5;

  logic [COMP_W-1:0] live_c [3];
  logic [COMP_W-1:0] held_c [3];

  for (genvar i = 0; i < 3; i++) begin : g_split
    assign live_c[i] = live_rgb[(3-i)*COMP_W-1 -: COMP_W];
    assign held_c[i] = held_rgb[(3-i)*COMP_W-1 -: COMP_W];
  end

  always_comb begin
    data = '0;
    if (serial) begin
      unique case (beat)
        2'd0:    data[COMP_W-1:0] = live_c[0];
        2'd1:    data[COMP_W-1:0] = held_c[1];
        default: data[COMP_W-1:0] = held_c[2];
      endcase
    end else if (bus18) begin
      data[3*C6-1:0] = {live_c[0][COMP_W-1 -: C6],
                        live_c[1][COMP_W-1 -: C6],
                        live_c[2][COMP_W-1 -: C6]};
    end else begin
      data[C5+C6+C5-1:0] = {live_c[0][COMP_W-1 -: C5],
                            live_c[1][COMP_W-1 -: C6],
                            live_c[2][COMP_W-1 -: C5]};
    end
  end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SYNC_W = 10,
  parameter int COMP_W = 8,
  parameter int DATA_W = 18
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_en,
  input  logic [CFG_W-1:0]    cfg_word,
  input  logic [SYNC_W-1:0]   hs_width,
  input  logic [SYNC_W-1:0]   vs_width,
  input  logic [2*CNT_W-1:0]  timing_total,
  input  logic [2*CNT_W-1:0]  h_window,
  input  logic [2*CNT_W-1:0]  v_window,
  input  logic [3*COMP_W-1:0] pix_rgb,
  output logic                pix_take,
  output logic                lcd_hsync,
  output logic                lcd_vsync,
  output logic                lcd_de,
  output logic [DATA_W-1:0]   lcd_data,
  output logic                lcd_pclk_fall,
  output logic                line_start,
  output logic                frame_start
);
  localparam int RGB_W = 3 * COMP_W;

  logic [CNT_W-1:0]  h_cnt;
  logic [CNT_W-1:0]  v_cnt;
  logic [1:0]        beat;
  logic              serial;
  logic              bus18;
  tg_flags_t         flags;
  logic [RGB_W-1:0]  rgb_hold;
  logic [DATA_W-1:0] fmt_data;
  logic              unused_cfg;

  assign serial     = panel_mode_e'(cfg_word[CFG_MODE_LSB +: CFG_MODE_W]) == MODE_SERIAL8;
  assign bus18      = cfg_word[CFG_BUS18];
  assign unused_cfg = ^cfg_word[CFG_BUS18-1:CFG_MODE_W];

  lcd_tg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .serial  (serial),
    .h_total (timing_total[2*CNT_W-1:CNT_W]),
    .v_total (timing_total[CNT_W-1:0]),
    .h_cnt   (h_cnt),
    .v_cnt   (v_cnt),
    .beat    (beat)
  );

  lcd_tg_window #(.CNT_W(CNT_W), .SYNC_W(SYNC_W)) u_win (
    .h_cnt    (h_cnt),
    .v_cnt    (v_cnt),
    .beat     (beat),
    .hs_width (hs_width),
    .vs_width (vs_width),
    .h_start  (h_window[2*CNT_W-1:CNT_W]),
    .h_end    (h_window[CNT_W-1:0]),
    .v_start  (v_window[2*CNT_W-1:CNT_W]),
    .v_end    (v_window[CNT_W-1:0]),
    .flags    (flags)
  );

  lcd_tg_pixfmt #(.COMP_W(COMP_W), .DATA_W(DATA_W)) u_fmt (
    .serial   (serial),
    .bus18    (bus18),
    .beat     (beat),
    .live_rgb (pix_rgb),
    .held_rgb (rgb_hold),
    .data     (fmt_data)
  );

  assign pix_take = tick_en && flags.de && (beat == 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      lcd_hsync     <= cfg_word[CFG_HS_LOW];
      lcd_vsync     <= cfg_word[CFG_VS_LOW];
      lcd_de        <= cfg_word[CFG_DE_LOW];
      lcd_data      <= '0;
      lcd_pclk_fall <= cfg_word[CFG_PCLK_FALL];
      line_start    <= 1'b0;
      frame_start   <= 1'b0;
      rgb_hold      <= '0;
    end else begin
      lcd_pclk_fall <= cfg_word[CFG_PCLK_FALL];
      if (pix_take) rgb_hold <= pix_rgb;
      if (tick_en) begin
        lcd_hsync   <= flags.hs ^ cfg_word[CFG_HS_LOW];
        lcd_vsync   <= flags.vs ^ cfg_word[CFG_VS_LOW];
        lcd_de      <= flags.de ^ cfg_word[CFG_DE_LOW];
        lcd_data    <= flags.de ? fmt_data : '0;
        line_start  <= flags.line_first;
        frame_start <= flags.frame_first;
      end
    end
  end
endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk
  import lcd_tg_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SYNC_W = 10,
  parameter int COMP_W = 8,
  parameter int DATA_W = 18
) (
  input logic                clk,
  input logic                rst,
  input logic                tick_en,
  input logic [CFG_W-1:0]    cfg_word,
  input logic [SYNC_W-1:0]   hs_width,
  input logic                pix_take,
  input logic                lcd_hsync,
  input logic                lcd_vsync,
  input logic                lcd_de,
  input logic [DATA_W-1:0]   lcd_data,
  input logic                lcd_pclk_fall,
  input logic                line_start,
  input logic                frame_start
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> ($stable(lcd_hsync) && $stable(lcd_vsync) && $stable(lcd_de) &&
                  $stable(lcd_data) && $stable(line_start) && $stable(frame_start)));

  assert_blank_data_R9: assert property (@(posedge clk) disable iff (rst)
    (lcd_de == cfg_word[CFG_DE_LOW]) |-> (lcd_data == '0));

  assert_take_tick_R9: assert property (@(posedge clk) disable iff (rst)
    pix_take |-> tick_en);

  assert_serial_pins_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_word[3:0] == MODE_SERIAL8) |-> (lcd_data[DATA_W-1:COMP_W] == '0));

  assert_frame_line_R12: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> line_start);

  assert_frame_sync_R2: assert property (@(posedge clk) disable iff (rst)
    (frame_start && hs_width != '0) |-> (lcd_hsync != cfg_word[CFG_HS_LOW]));

  assert_pclk_edge_R5: assert property (@(posedge clk) disable iff (rst)
    lcd_pclk_fall == $past(cfg_word[CFG_PCLK_FALL]));
endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(
  .CNT_W(CNT_W), .SYNC_W(SYNC_W), .COMP_W(COMP_W), .DATA_W(DATA_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .tick_en       (tick_en),
  .cfg_word      (cfg_word),
  .hs_width      (hs_width),
  .pix_take      (pix_take),
  .lcd_hsync     (lcd_hsync),
  .lcd_vsync     (lcd_vsync),
  .lcd_de        (lcd_de),
  .lcd_data      (lcd_data),
  .lcd_pclk_fall (lcd_pclk_fall),
  .line_start    (line_start),
  .frame_start   (frame_start)
);

// File: tb/lcd_timing_gen_test.sv
module lcd_timing_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic [11:0] cfg_word = '0;
  logic [9:0]  hs_width = '0;
  logic [9:0]  vs_width = '0;
  logic [31:0] timing_total = '0;
  logic [31:0] h_window = '0;
  logic [31:0] v_window = '0;
  logic [23:0] pix_rgb = '0;
  logic        pix_take;
  logic        lcd_hsync, lcd_vsync, lcd_de, lcd_pclk_fall, line_start, frame_start;
  logic [17:0] lcd_data;

  int checks = 0;
  int errors = 0;
  int ht, vt, hsw, vsw, hs0, he0, vs0, ve0;

  always #2.5 clk = ~clk;

  lcd_timing_gen uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .cfg_word(cfg_word),
    .hs_width(hs_width), .vs_width(vs_width), .timing_total(timing_total),
    .h_window(h_window), .v_window(v_window), .pix_rgb(pix_rgb),
    .pix_take(pix_take), .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync),
    .lcd_de(lcd_de), .lcd_data(lcd_data), .lcd_pclk_fall(lcd_pclk_fall),
    .line_start(line_start), .frame_start(frame_start)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] pat(int p);
    return 24'hA5C30F ^ (24'(p) * 24'h013579);
  endfunction

  function automatic logic [17:0] fmt(bit ser, bit b18, int bt, logic [23:0] c);
    if (ser) return (bt == 0) ? {10'b0, c[23:16]} : (bt == 1) ? {10'b0, c[15:8]} : {10'b0, c[7:0]};
    if (b18) return {c[23:18], c[15:10], c[7:2]};
    return {2'b0, c[23:19], c[15:10], c[7:3]};
  endfunction

  task automatic setup(logic [11:0] cfg, int a_ht, int a_vt, int a_hsw, int a_vsw,
                       int a_hs0, int a_he0, int a_vs0, int a_ve0);
    ht = a_ht; vt = a_vt; hsw = a_hsw; vsw = a_vsw;
    hs0 = a_hs0; he0 = a_he0; vs0 = a_vs0; ve0 = a_ve0;
    cfg_word     = cfg;
    hs_width     = 10'(hsw);
    vs_width     = 10'(vsw);
    timing_total = {16'(ht), 16'(vt)};
    h_window     = {16'(hs0), 16'(he0)};
    v_window     = {16'(vs0), 16'(ve0)};
  endtask

  // R11: reset state, physical inactive levels follow the polarity bits
  task automatic do_reset(string tag);
    rst = 1'b1;
    tick_en = 1'b0;
    repeat (3) @(negedge clk);
    chk({tag, " R11 hsync"}, 32'(lcd_hsync), 32'(cfg_word[11]));
    chk({tag, " R11 vsync"}, 32'(lcd_vsync), 32'(cfg_word[8]));
    chk({tag, " R11 de"}, 32'(lcd_de), 32'(cfg_word[9]));
    chk({tag, " R11 data"}, 32'(lcd_data), 32'd0);
    chk({tag, " R11 status"}, {30'd0, line_start, frame_start}, 32'd0);
    rst = 1'b0;
  endtask

  // Runs ncyc cycles; compares every output against positions computed here.
  task automatic run_scene(string tag, int ncyc, bit stall);
    bit ser = (cfg_word[3:0] == 4'h1);
    bit b18 = cfg_word[7];
    int k = 0;
    logic eh = cfg_word[11], ev = cfg_word[8], ed = cfg_word[9];
    logic [17:0] edata = '0;
    logic el = 1'b0, ef = 1'b0;
    for (int cyc = 0; cyc < ncyc; cyc++) begin
      int p, bt, h, v;
      bit hs, vs, de, te;
      chk({tag, " hsync"}, 32'(lcd_hsync), 32'(eh));
      chk({tag, " vsync"}, 32'(lcd_vsync), 32'(ev));
      chk({tag, " de"}, 32'(lcd_de), 32'(ed));
      chk({tag, " data"}, 32'(lcd_data), 32'(edata));
      chk({tag, " R12 line_start"}, 32'(line_start), 32'(el));
      chk({tag, " R12 frame_start"}, 32'(frame_start), 32'(ef));
      chk({tag, " R5 pclk_fall"}, 32'(lcd_pclk_fall), 32'(cfg_word[10]));
      p  = ser ? k / 3 : k;
      bt = ser ? k % 3 : 0;
      h  = p % ht;
      v  = (p / ht) % vt;
      hs = h < hsw;
      vs = v < vsw;
      de = (h >= hs0) && (h < he0) && (v >= vs0) && (v < ve0);
      te = stall ? (cyc % 3 != 2) : 1'b1;
      tick_en = te;
      pix_rgb = pat(p);
      #1;
      chk({tag, " R9 pix_take"}, 32'(pix_take), 32'(te && de && bt == 0));
      if (te) begin
        eh = hs ^ cfg_word[11];
        ev = vs ^ cfg_word[8];
        ed = de ^ cfg_word[9];
        edata = de ? fmt(ser, b18, bt, pat(p)) : 18'd0;
        el = (h == 0) && (bt == 0);
        ef = el && (v == 0);
        k++;
      end
      @(negedge clk);
    end
    tick_en = 1'b0;
  endtask

  task automatic test_parallel16();
    setup(12'h000, 10, 5, 2, 1, 3, 7, 2, 4);
    do_reset("par16");
    run_scene("par16 R1 R2 R3 R4 R6", 120, 1'b0);
  endtask

  task automatic test_parallel18_inverted();
    setup(12'hF80, 12, 4, 3, 2, 4, 12, 2, 4);
    do_reset("par18inv");
    run_scene("par18inv R1 R2 R3 R5 R7", 110, 1'b0);
  endtask

  task automatic test_serial();
    setup(12'h001, 8, 4, 1, 1, 2, 6, 1, 3);
    do_reset("serial");
    run_scene("serial R1 R3 R8 R9", 210, 1'b0);
  endtask

  task automatic test_serial_ignores_bus18();
    setup(12'h081, 6, 3, 2, 1, 2, 5, 0, 2);
    do_reset("serial18");
    run_scene("serial18 R6 R8", 120, 1'b0);
  endtask

  task automatic test_stall();
    setup(12'h200, 9, 4, 2, 1, 1, 8, 1, 3);
    do_reset("stall");
    run_scene("stall R10 R3", 150, 1'b1);
  endtask

  task automatic test_serial_stall();
    setup(12'h901, 7, 3, 2, 1, 3, 6, 1, 3);
    do_reset("serstall");
    run_scene("serstall R10 R8 R5", 150, 1'b1);
  endtask

  initial begin
    #(200000 * 5ns);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    test_parallel16();
    test_parallel18_inverted();
    test_serial();
    test_serial_ignores_bus18();
    test_stall();
    test_serial_stall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule